// File: doc/BRIEF.md
# Eight-Pin Bus GPIO with Address-Masked Data Port

This block is a general-purpose I/O controller for eight pins, attached as a slave to an APB register bus with no wait states. Each pin can be driven or sampled by software, or handed over to an alternate hardware source that drives the pad value and the pad enable directly. The data port is spread across the low part of the address window. Address bits [9:2] act as a per-pin mask, so software can update or sample one pin, or any subset of pins, in a single access without a read-modify-write.

Pad inputs are brought into the clock domain through a two-flop synchroniser. Each pin has an interrupt detector that is configured per pin. It watches either for a level or for an edge, and an edge can be the rising edge, the falling edge or both. Detected edges are latched in a raw status register until software clears them. The enabled status bits are ORed into a single interrupt line.

A small bus-phase state machine tracks the APB transfer. Its states are `BUS_IDLE`, `BUS_SETUP` and `BUS_ACCESS`. From `BUS_IDLE` it moves to `BUS_SETUP` when the slave is selected while the enable is low. From `BUS_SETUP` it moves to `BUS_ACCESS` once the enable rises. It stays in `BUS_SETUP` while the select is held with the enable low, and it returns to `BUS_IDLE` if the select drops. From `BUS_ACCESS` it moves back to `BUS_SETUP` for a back-to-back setup, or otherwise to `BUS_IDLE`. A read or write is only honoured in an access cycle that follows a setup cycle.

Top module: `gpio8_apb`

## Requirements
- R1: After reset every register reads 0. `pad_oe`, `pad_out` and `irq` are 0, so every pin starts as a software-controlled input with its interrupt disabled.
- R2: A read with `paddr[11:10]`=0 returns, for each pin i, the synchronised pad value when `paddr[i+2]`=1 and 0 when `paddr[i+2]`=0. A pad change becomes readable two clock edges after it is applied.
- R3: A write with `paddr[11:10]`=0 loads `pwdata[i]` into output bit i only where `paddr[i+2]`=1. All other output bits keep their value.
- R4: The direction register at offset 0x400 reads back what was written. For a pin whose mode bit is 0, `pad_oe[i]` equals the direction bit (1 = output) and `pad_out[i]` equals the data output bit.
- R5: The mode register at offset 0x420 reads back what was written. For a pin whose mode bit is 1, `pad_out[i]` follows `alt_out[i]` and `pad_oe[i]` follows `alt_oe[i]`.
- R6: When the sense bit (offset 0x404) is 0, a pin detects edges. A both-edges bit (0x408) of 1 latches either edge. Otherwise the polarity bit (0x40C) selects the rising edge (1) or the falling edge (0). Latched edges show in raw status (0x414) three clock edges after the pad changes.
- R7: When the sense bit is 1, raw status follows the synchronised pad directly: polarity 1 asserts on a high level and polarity 0 on a low level. Writing the clear register has no effect on a pin in level mode.
- R8: Writing 1 to bit i of the clear register (0x41C) removes a latched edge on pin i. Bits written 0 are left alone. The clear register reads as 0.
- R9: Masked status (0x418) equals raw status AND the enable register (0x410). `irq` is 1 exactly when some masked status bit is 1.
- R10: A write changes state only in an access cycle (`psel`=1, `penable`=1) that directly follows a setup cycle (`psel`=1, `penable`=0). Offsets with `paddr[1:0]`≠0, or offsets outside the map, ignore writes and read 0. `prdata` is 0 outside a valid read access.
- R11: The sense, both-edges, polarity and enable registers read back the values written to them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Bus slave select |
| penable | input | 1 | Bus access-phase strobe |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 12 | Byte address within the block window |
| pwdata | input | 8 | Write data, one bit per pin |
| prdata | output | 8 | Read data, valid during the access cycle |
| pad_in | input | 8 | Asynchronous pad input values |
| pad_out | output | 8 | Pad drive values |
| pad_oe | output | 8 | Pad output enables (1 = drive) |
| alt_out | input | 8 | Alternate hardware drive values |
| alt_oe | input | 8 | Alternate hardware output enables |
| irq | output | 1 | Combined interrupt request |

## Verification
The bus assertions assume a well-formed APB master: `paddr`, `pwrite` and `pwdata` are held constant from the setup cycle through the access cycle, and `penable` is raised only after a setup cycle. The bench's transfer tasks follow this pattern for every normal access. The one deliberate exception is a single lone access cycle, used to check that such a write is dropped. The edge checks also assume that pad inputs stay stable for several clocks around each change. The bench changes pads only between bus transfers and then waits at least four clock edges before it samples.

// File: rtl/gpio8_pkg.sv
package gpio8_pkg;

    localparam int ADDR_W = 12;

    typedef enum logic [1:0] {
        BUS_IDLE,
        BUS_SETUP,
        BUS_ACCESS
    } bus_state_t;

    typedef enum logic [3:0] {
        SEL_DATA,
        SEL_DIR,
        SEL_SENSE,
        SEL_BOTH,
        SEL_POL,
        SEL_EN,
        SEL_RAW,
        SEL_MSK,
        SEL_CLR,
        SEL_MODE,
        SEL_NONE
    } reg_sel_t;

    localparam logic [ADDR_W-1:0] OFS_DIR   = 12'h400;
    localparam logic [ADDR_W-1:0] OFS_SENSE = 12'h404;
    localparam logic [ADDR_W-1:0] OFS_BOTH  = 12'h408;
    localparam logic [ADDR_W-1:0] OFS_POL   = 12'h40C;
    localparam logic [ADDR_W-1:0] OFS_EN    = 12'h410;
    localparam logic [ADDR_W-1:0] OFS_RAW   = 12'h414;
    localparam logic [ADDR_W-1:0] OFS_MSK   = 12'h418;
    localparam logic [ADDR_W-1:0] OFS_CLR   = 12'h41C;
    localparam logic [ADDR_W-1:0] OFS_MODE  = 12'h420;

    function automatic reg_sel_t decode_addr(input logic [ADDR_W-1:0] a);
        reg_sel_t s;
        if (a[1:0] != 2'b00) begin
            s = SEL_NONE;
        end else if (a[ADDR_W-1:10] == '0) begin
            s = SEL_DATA;
        end else begin
            case (a)
                OFS_DIR:   s = SEL_DIR;
                OFS_SENSE: s = SEL_SENSE;
                OFS_BOTH:  s = SEL_BOTH;
                OFS_POL:   s = SEL_POL;
                OFS_EN:    s = SEL_EN;
                OFS_RAW:   s = SEL_RAW;
                OFS_MSK:   s = SEL_MSK;
                OFS_CLR:   s = SEL_CLR;
                OFS_MODE:  s = SEL_MODE;
                default:   s = SEL_NONE;
            endcase
        end
        return s;
    endfunction

endpackage

// File: rtl/gpio8_sync.sv
module gpio8_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [STAGES-1:0][W-1:0] stg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg <= '0;
        end else begin
            stg <= {stg[STAGES-2:0], din};
        end
    end

    assign dout = stg[STAGES-1];
endmodule

// File: rtl/gpio8_bus_fsm.sv
module gpio8_bus_fsm
    import gpio8_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    output logic              wr_en,
    output logic              rd_en,
    output reg_sel_t          sel
);
    bus_state_t state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= BUS_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = BUS_IDLE;
        unique case (state)
            BUS_IDLE:   state_nx = (psel && !penable) ? BUS_SETUP : BUS_IDLE;
            BUS_SETUP: begin
                if (psel && penable)  state_nx = BUS_ACCESS;
                else if (psel)        state_nx = BUS_SETUP;
                else                  state_nx = BUS_IDLE;
            end
            BUS_ACCESS: state_nx = (psel && !penable) ? BUS_SETUP : BUS_IDLE;
            default:    state_nx = BUS_IDLE;
        endcase
    end

    always_comb begin
        wr_en = 1'b0;
        rd_en = 1'b0;
        if (state == BUS_SETUP && psel && penable) begin
            wr_en = pwrite;
            rd_en = !pwrite;
        end
        sel = decode_addr(paddr);
    end
endmodule

// File: rtl/gpio8_irq.sv
module gpio8_irq #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl,
    input  logic [N-1:0] sense,
    input  logic [N-1:0] both,
    input  logic [N-1:0] pol,
    input  logic [N-1:0] en,
    input  logic         clr_wr,
    input  logic [N-1:0] clr_bits,
    output logic [N-1:0] raw,
    output logic [N-1:0] masked,
    output logic         irq
);
    logic [N-1:0] prev_q;
    logic [N-1:0] latch_q;
    logic [N-1:0] hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= lvl;
    end

    for (genvar i = 0; i < N; i++) begin : g_pin
        logic rise, fall;
        assign rise   = lvl[i] & ~prev_q[i];
        assign fall   = ~lvl[i] & prev_q[i];
        assign hit[i] = ~sense[i] & (both[i] ? (rise | fall)
                                             : (pol[i] ? rise : fall));
        assign raw[i] = sense[i] ? ~(lvl[i] ^ pol[i]) : latch_q[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            latch_q <= '0;
        end else begin
            latch_q <= (latch_q & ~(clr_wr ? clr_bits : '0)) | hit;
        end
    end

    assign masked = raw & en;
    assign irq    = |masked;
endmodule

// File: rtl/gpio8_apb.sv
module gpio8_apb
    import gpio8_pkg::*;
#(
    parameter int N_PINS = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [N_PINS-1:0] pwdata,
    output logic [N_PINS-1:0] prdata,
    input  logic [N_PINS-1:0] pad_in,
    output logic [N_PINS-1:0] pad_out,
    output logic [N_PINS-1:0] pad_oe,
    input  logic [N_PINS-1:0] alt_out,
    input  logic [N_PINS-1:0] alt_oe,
    output logic              irq
);
    localparam int MASK_LO = 2;
    localparam int MASK_HI = MASK_LO + N_PINS - 1;

    logic              wr_en, rd_en;
    reg_sel_t          sel;
    logic [N_PINS-1:0] mask;
    logic [N_PINS-1:0] pin_s;
    logic [N_PINS-1:0] dout_q, dir_q, sense_q, both_q, pol_q, ie_q, mode_q;
    logic [N_PINS-1:0] raw_st, msk_st;

    assign mask = paddr[MASK_HI:MASK_LO];

    gpio8_bus_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .psel    (psel),
        .penable (penable),
        .pwrite  (pwrite),
        .paddr   (paddr),
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .sel     (sel)
    );

    gpio8_sync #(.W(N_PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (pad_in),
        .dout  (pin_s)
    );

    gpio8_irq #(.N(N_PINS)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .lvl      (pin_s),
        .sense    (sense_q),
        .both     (both_q),
        .pol      (pol_q),
        .en       (ie_q),
        .clr_wr   (wr_en && sel == SEL_CLR),
        .clr_bits (pwdata),
        .raw      (raw_st),
        .masked   (msk_st),
        .irq      (irq)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout_q  <= '0;
            dir_q   <= '0;
            sense_q <= '0;
            both_q  <= '0;
            pol_q   <= '0;
            ie_q    <= '0;
            mode_q  <= '0;
        end else if (wr_en) begin
            case (sel)
                SEL_DATA:  dout_q  <= (dout_q & ~mask) | (pwdata & mask);
                SEL_DIR:   dir_q   <= pwdata;
                SEL_SENSE: sense_q <= pwdata;
                SEL_BOTH:  both_q  <= pwdata;
                SEL_POL:   pol_q   <= pwdata;
                SEL_EN:    ie_q    <= pwdata;
                SEL_MODE:  mode_q  <= pwdata;
                default:   ;
            endcase
        end
    end

    always_comb begin
        prdata = '0;
        if (rd_en) begin
            case (sel)
                SEL_DATA:  prdata = pin_s & mask;
                SEL_DIR:   prdata = dir_q;
                SEL_SENSE: prdata = sense_q;
                SEL_BOTH:  prdata = both_q;
                SEL_POL:   prdata = pol_q;
                SEL_EN:    prdata = ie_q;
                SEL_RAW:   prdata = raw_st;
                SEL_MSK:   prdata = msk_st;
                SEL_MODE:  prdata = mode_q;
                default:   prdata = '0;
            endcase
        end
    end

    for (genvar i = 0; i < N_PINS; i++) begin : g_pad
        assign pad_out[i] = mode_q[i] ? alt_out[i] : dout_q[i];
        assign pad_oe[i]  = mode_q[i] ? alt_oe[i]  : dir_q[i];
    end
endmodule

// File: rtl/gpio8_apb_checker.sv
module gpio8_apb_checker
    import gpio8_pkg::*;
#(
    parameter int N_PINS = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              psel,
    input logic              penable,
    input logic              pwrite,
    input logic [ADDR_W-1:0] paddr,
    input logic [N_PINS-1:0] pwdata,
    input logic [N_PINS-1:0] prdata,
    input logic              irq,
    input logic              wr_en,
    input reg_sel_t          sel,
    input logic [N_PINS-1:0] dout_q,
    input logic [N_PINS-1:0] dir_q,
    input logic [N_PINS-1:0] mode_q,
    input logic [N_PINS-1:0] ie_q
);
    localparam int MHI = N_PINS + 1;

    assert_keep_unmasked_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_DATA) |=>
            ((dout_q & ~$past(paddr[MHI:2])) == ($past(dout_q) & ~$past(paddr[MHI:2]))));

    assert_take_masked_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_DATA) |=>
            ((dout_q & $past(paddr[MHI:2])) == ($past(pwdata) & $past(paddr[MHI:2]))));

    assert_read_masked_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (psel && penable && !pwrite && paddr[ADDR_W-1:10] == '0) |->
            ((prdata & ~paddr[MHI:2]) == '0));

    assert_clear_reads_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (psel && penable && !pwrite && paddr == OFS_CLR) |-> (prdata == '0));

    assert_no_stray_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(psel && penable && pwrite) |=>
            ($stable(dir_q) && $stable(mode_q) && $stable(ie_q) && $stable(dout_q)));

    assert_idle_prdata_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(psel && penable) |-> (prdata == '0));

    assert_irq_needs_enable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> (ie_q != '0));
endmodule

bind gpio8_apb gpio8_apb_checker #(.N_PINS(N_PINS)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .psel    (psel),
    .penable (penable),
    .pwrite  (pwrite),
    .paddr   (paddr),
    .pwdata  (pwdata),
    .prdata  (prdata),
    .irq     (irq),
    .wr_en   (wr_en),
    .sel     (sel),
    .dout_q  (dout_q),
    .dir_q   (dir_q),
    .mode_q  (mode_q),
    .ie_q    (ie_q)
);

// File: tb/gpio8_apb_test.sv
`timescale 1ns/1ps
module gpio8_apb_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [11:0] paddr = '0;
    logic [7:0]  pwdata = '0;
    logic [7:0]  prdata;
    logic [7:0]  pad_in = '0;
    logic [7:0]  pad_out, pad_oe;
    logic [7:0]  alt_out = '0, alt_oe = '0;
    logic        irq;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    gpio8_apb uut (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
        .alt_out(alt_out), .alt_oe(alt_oe), .irq(irq)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [7:0] d);
        @(negedge clk);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = d;
        @(negedge clk);
        penable = 1'b1;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [7:0] d);
        @(negedge clk);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a;
        @(negedge clk);
        penable = 1'b1;
        #1 d = prdata;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0;
    endtask

    task automatic settle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    initial begin
        #1000000;
        total++;
        bad++;
        $display("FAIL watchdog actual=%h expected=%h", 8'h00, 8'h01);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] d;
        logic [7:0] exp_out;
        logic [7:0] w;
        logic [7:0] p;
        settle(4);
        rst_n = 1'b1;
        settle(2);

        // R1: reset state
        chk("R1 pad_oe", pad_oe, 8'h00);
        chk("R1 pad_out", pad_out, 8'h00);
        chk("R1 irq", {7'd0, irq}, 8'h00);
        for (int r = 0; r < 9; r++) begin
            rd(12'h400 + 12'(r * 4), d);
            chk("R1 reg", d, 8'h00);
        end

        // R11: readback of configuration registers
        wr(12'h404, 8'h5A); rd(12'h404, d); chk("R11 sense", d, 8'h5A);
        wr(12'h408, 8'hC3); rd(12'h408, d); chk("R11 both", d, 8'hC3);
        wr(12'h40C, 8'h96); rd(12'h40C, d); chk("R11 pol", d, 8'h96);
        wr(12'h410, 8'h3C); rd(12'h410, d); chk("R11 en", d, 8'h3C);
        wr(12'h404, 8'h00); wr(12'h408, 8'h00); wr(12'h40C, 8'h00); wr(12'h410, 8'h00);

        // R2: masked read sweep over all masks
        for (int pi = 0; pi < 2; pi++) begin
            p = (pi == 0) ? 8'h5A : 8'hC3;
            pad_in = p;
            settle(3);
            for (int m = 0; m < 256; m++) begin
                rd({2'b00, 8'(m), 2'b00}, d);
                chk("R2 masked read", d, p & 8'(m));
            end
        end
        // R2: two-edge latency
        @(negedge clk);
        pad_in = 8'h81;
        rd(12'h3FC, d);
        chk("R2 latency", d, 8'h81);
        pad_in = 8'h00;
        settle(4);

        // R3 / R4: masked write sweep
        wr(12'h400, 8'hFF);
        rd(12'h400, d); chk("R4 dir readback", d, 8'hFF);
        chk("R4 pad_oe", pad_oe, 8'hFF);
        exp_out = 8'h00;
        for (int m = 0; m < 256; m++) begin
            w = 8'(m * 37 + 5);
            wr({2'b00, 8'(m), 2'b00}, w);
            exp_out = (exp_out & ~8'(m)) | (w & 8'(m));
            chk("R3 masked write", pad_out, exp_out);
        end
        wr(12'h400, 8'h3C);
        chk("R4 pad_oe dir", pad_oe, 8'h3C);

        // R5: alternate function hand-over
        alt_out = 8'hAA; alt_oe = 8'h0F;
        wr(12'h420, 8'hF0);
        rd(12'h420, d); chk("R5 mode readback", d, 8'hF0);
        chk("R5 pad_out", pad_out, (8'hAA & 8'hF0) | (exp_out & 8'h0F));
        chk("R5 pad_oe", pad_oe, 8'h0C);
        wr(12'h420, 8'h00);
        chk("R5 back to sw", pad_out, exp_out);

        // R10: access without setup is dropped
        @(negedge clk);
        psel = 1'b1; penable = 1'b1; pwrite = 1'b1; paddr = 12'h400; pwdata = 8'hFF;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
        rd(12'h400, d); chk("R10 lone access", d, 8'h3C);
        wr(12'h401, 8'hFF);
        rd(12'h400, d); chk("R10 misaligned", d, 8'h3C);
        wr(12'h430, 8'hFF);
        rd(12'h430, d); chk("R10 unmapped", d, 8'h00);
        #1 chk("R10 idle prdata", prdata, 8'h00);

        // R6: edge detection
        pad_in = 8'h00;
        settle(4);
        wr(12'h408, 8'h01);
        wr(12'h40C, 8'h02);
        wr(12'h41C, 8'hFF);
        rd(12'h414, d); chk("R6 raw cleared", d, 8'h00);
        @(negedge clk);
        pad_in = 8'h07;
        settle(4);
        rd(12'h414, d); chk("R6 rising", d, 8'h03);
        wr(12'h41C, 8'hFF);
        @(negedge clk);
        pad_in = 8'h00;
        settle(4);
        rd(12'h414, d); chk("R6 falling", d, 8'h05);

        // R8: selective clear
        wr(12'h41C, 8'h01);
        rd(12'h414, d); chk("R8 clear one", d, 8'h04);
        rd(12'h41C, d); chk("R8 clear reads 0", d, 8'h00);

        // R9: masked status and irq
        wr(12'h410, 8'h04);
        rd(12'h418, d); chk("R9 masked", d, 8'h04);
        chk("R9 irq on", {7'd0, irq}, 8'h01);
        wr(12'h410, 8'h02);
        rd(12'h418, d); chk("R9 masked off", d, 8'h00);
        chk("R9 irq off", {7'd0, irq}, 8'h00);
        wr(12'h41C, 8'hFF);

        // R7: level detection
        wr(12'h404, 8'h80);
        wr(12'h40C, 8'h82);
        rd(12'h414, d); chk("R7 level low", d, 8'h00);
        @(negedge clk);
        pad_in = 8'h80;
        settle(3);
        rd(12'h414, d); chk("R7 level high", d, 8'h80);
        wr(12'h410, 8'h80);
        chk("R7 irq level", {7'd0, irq}, 8'h01);
        wr(12'h41C, 8'h80);
        rd(12'h414, d); chk("R7 clear ignored", d, 8'h80);
        @(negedge clk);
        pad_in = 8'h00;
        settle(4);
        rd(12'h414, d); chk("R7 level gone", d, 8'h00);
        chk("R7 irq gone", {7'd0, irq}, 8'h00);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule